// File: doc/BRIEF.md
# Driver Impedance Segment Splitter

This block turns the raw pull-up (P) and pull-down (N) impedance calibration results of a serial transmitter into the six segment-enable codes that program the output driver. Each raw result is given in eighth-segment steps. The block first scales it to quarter-segment steps. It then either keeps the value inside a legal window or replaces it with a nominal setting when calibration never completed.

The quarter-step value for each polarity is then divided into three portions. A margin portion is counted twice, once for each side of the driver. A post-cursor tap portion is taken from what remains. The main portion is whatever is left after that. Two 8-bit ratios, each in 1/128 steps, set the size of the margin and tap portions. Every portion is rounded to a half-step register code. Each clamp that took effect raises a warning flag.

Firmware or a sequencer presents the inputs and pulses `start`. One clock later, `res_valid` pulses and the codes and warnings show the result. Codes and warnings keep their values until the next `start`.

Top module: `zcal_seg_split`

## Requirements
- R1: While `rst` is high and after it is released, `res_valid` is 0 and all six codes and all four warning bits are 0 until the first `start`.
- R2: When `start` is high at a rising edge, `res_valid` is 1 for the following cycle, and that cycle shows the results for the inputs sampled at that edge. In any cycle that follows an edge where `start` was low, `res_valid` is 0, and codes and warnings keep their values no matter what the other inputs do.
- R3: The quarter-step value q of each polarity is its 9-bit raw result divided by 2, with the fraction dropped.
- R4: When `cal_ok` is 0, q is 100 for both polarities and all warning bits are 0.
- R5: When `cal_ok` is 1 and the scaled value is above 132, q becomes 132 and that polarity's `warn_high` bit is set. Bit 0 is P and bit 1 is N.
- R6: When `cal_ok` is 1 and the scaled value is below 64, q becomes 64 and that polarity's `warn_low` bit is set. Bit 0 is P and bit 1 is N.
- R7: The margin portion m is floor(min(margin_ratio,128) × floor(q/2) / 128).
- R8: The post-cursor portion t is floor(min(tap_ratio,128) × (q − 2m) / 128).
- R9: The main portion is q − 2m − t.
- R10: Every code is its portion v rounded half up to half resolution, which equals (v+1)>>1. An odd v gives (v>>1)+1 and an even v gives v>>1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the inputs and compute |
| cal_ok | input | 1 | Calibration completed; the raw results are usable |
| raw_p | input | 9 | Pull-up result, eighth-segment units |
| raw_n | input | 9 | Pull-down result, eighth-segment units |
| margin_ratio | input | 8 | Margin share, 1/128 units |
| tap_ratio | input | 8 | Post-cursor share, 1/128 units |
| res_valid | output | 1 | One-cycle pulse, results valid |
| margin_p_code | output | 8 | P margin code |
| margin_n_code | output | 8 | N margin code |
| post_p_code | output | 8 | P post-cursor code |
| post_n_code | output | 8 | N post-cursor code |
| main_p_code | output | 8 | P main code |
| main_n_code | output | 8 | N main code |
| warn_high | output | 2 | Upper clamp applied ([0]=P, [1]=N) |
| warn_low | output | 2 | Lower clamp applied ([0]=P, [1]=N) |

## Verification
The hardest corners to reach are ratio values above full scale combined with values at the edges of the clamp window. Without saturation, the doubled margin would exceed q there and the main portion would wrap. The stimulus sweeps every 9-bit raw value on P while N takes the mirrored value. It repeats this for a set of ratio pairs that includes 0, half scale, full scale, and 200 and 255. Mirroring puts one polarity in the upper clamp while the other sits in the lower clamp. After each result, the bench scrambles the inputs with `start` low and confirms that the held codes do not move.

// File: rtl/zseg_pkg.sv
package zseg_pkg;
  // Polarity index used for the per-polarity arrays and warning bits.
  typedef enum logic {
    POL_P = 1'b0,
    POL_N = 1'b1
  } zseg_pol_e;

  localparam int unsigned NUM_POL = 2;
endpackage

// File: rtl/zseg_clamp.sv
// Scales an eighth-step result to quarter steps, then clamps it or
// substitutes the nominal value.
module zseg_clamp #(
  parameter int unsigned RAW_W = 9,
  parameter int unsigned Q_W   = 8,
  parameter int unsigned Q_MIN = 64,
  parameter int unsigned Q_MAX = 132,
  parameter int unsigned Q_DEF = 100
) (
  input  logic [RAW_W-1:0] raw,
  input  logic             cal_ok,
  output logic [Q_W-1:0]   q,
  output logic             clip_hi,
  output logic             clip_lo
);
  localparam int unsigned SC_W = RAW_W - 1;
  localparam logic [SC_W-1:0] LIM_HI = SC_W'(Q_MAX);
  localparam logic [SC_W-1:0] LIM_LO = SC_W'(Q_MIN);

  logic [SC_W-1:0] scaled;

  assign scaled = raw[RAW_W-1:1];

  always_comb begin
    clip_hi = 1'b0;
    clip_lo = 1'b0;
    if (!cal_ok) begin
      q = Q_W'(Q_DEF);
    end else if (scaled > LIM_HI) begin
      q       = Q_W'(Q_MAX);
      clip_hi = 1'b1;
    end else if (scaled < LIM_LO) begin
      q       = Q_W'(Q_MIN);
      clip_lo = 1'b1;
    end else begin
      q = Q_W'(scaled);
    end
  end
endmodule

// File: rtl/zseg_split.sv
// Splits a quarter-step value into margin, post-cursor and main portions.
module zseg_split #(
  parameter int unsigned Q_W     = 8,
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned FRAC    = 7
) (
  input  logic [Q_W-1:0]     q,
  input  logic [RATIO_W-1:0] m_ratio,
  input  logic [RATIO_W-1:0] k_ratio,
  output logic [Q_W-1:0]     margin,
  output logic [Q_W-1:0]     post,
  output logic [Q_W-1:0]     main
);
  localparam int unsigned PR_W = RATIO_W + Q_W;
  localparam logic [RATIO_W-1:0] FULL = RATIO_W'(1 << FRAC);

  logic [RATIO_W-1:0] m_sat, k_sat;
  logic [Q_W-1:0]     half;
  logic [PR_W-1:0]    m_prod, k_prod;
  logic [Q_W-1:0]     rest;

  // Ratios beyond full scale are held at full scale.
  assign m_sat = (m_ratio > FULL) ? FULL : m_ratio;
  assign k_sat = (k_ratio > FULL) ? FULL : k_ratio;

  assign half   = q >> 1;
  assign m_prod = PR_W'(m_sat) * PR_W'(half);
  assign margin = Q_W'(m_prod >> FRAC);
  assign rest   = q - (margin << 1);
  assign k_prod = PR_W'(k_sat) * PR_W'(rest);
  assign post   = Q_W'(k_prod >> FRAC);
  assign main   = rest - post;
endmodule

// File: rtl/zseg_round.sv
// Halves a quarter-step portion, rounding half up.
module zseg_round #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 8
) (
  input  logic [IN_W-1:0]  val,
  output logic [OUT_W-1:0] code
);
  logic [IN_W:0] sum;

  assign sum  = {1'b0, val} + {{IN_W{1'b0}}, 1'b1};
  assign code = OUT_W'(sum >> 1);
endmodule

// File: rtl/zcal_seg_split.sv
module zcal_seg_split #(
  parameter int unsigned RAW_W   = 9,
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned FRAC    = 7,
  parameter int unsigned Q_MIN   = 64,
  parameter int unsigned Q_MAX   = 132,
  parameter int unsigned Q_DEF   = 100,
  parameter int unsigned CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               cal_ok,
  input  logic [RAW_W-1:0]   raw_p,
  input  logic [RAW_W-1:0]   raw_n,
  input  logic [RATIO_W-1:0] margin_ratio,
  input  logic [RATIO_W-1:0] tap_ratio,
  output logic               res_valid,
  output logic [CODE_W-1:0]  margin_p_code,
  output logic [CODE_W-1:0]  margin_n_code,
  output logic [CODE_W-1:0]  post_p_code,
  output logic [CODE_W-1:0]  post_n_code,
  output logic [CODE_W-1:0]  main_p_code,
  output logic [CODE_W-1:0]  main_n_code,
  output logic [1:0]         warn_high,
  output logic [1:0]         warn_low
);
  import zseg_pkg::*;

  localparam int unsigned Q_W = $clog2(Q_MAX + 1);

  logic [RAW_W-1:0]  raw_a  [NUM_POL];
  logic [CODE_W-1:0] mar_q  [NUM_POL];
  logic [CODE_W-1:0] pst_q  [NUM_POL];
  logic [CODE_W-1:0] man_q  [NUM_POL];
  logic [NUM_POL-1:0] hi_q, lo_q;
  logic               vld_q;

  assign raw_a[POL_P] = raw_p;
  assign raw_a[POL_N] = raw_n;

  for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
    logic [Q_W-1:0]    q_v, mar_v, pst_v, man_v;
    logic [CODE_W-1:0] mar_c, pst_c, man_c;
    logic              c_hi, c_lo;

    zseg_clamp #(
      .RAW_W(RAW_W), .Q_W(Q_W), .Q_MIN(Q_MIN), .Q_MAX(Q_MAX), .Q_DEF(Q_DEF)
    ) i_clamp (
      .raw(raw_a[g]), .cal_ok(cal_ok), .q(q_v),
      .clip_hi(c_hi), .clip_lo(c_lo)
    );

    zseg_split #(.Q_W(Q_W), .RATIO_W(RATIO_W), .FRAC(FRAC)) i_split (
      .q(q_v), .m_ratio(margin_ratio), .k_ratio(tap_ratio),
      .margin(mar_v), .post(pst_v), .main(man_v)
    );

    zseg_round #(.IN_W(Q_W), .OUT_W(CODE_W)) i_rnd_mar (.val(mar_v), .code(mar_c));
    zseg_round #(.IN_W(Q_W), .OUT_W(CODE_W)) i_rnd_pst (.val(pst_v), .code(pst_c));
    zseg_round #(.IN_W(Q_W), .OUT_W(CODE_W)) i_rnd_man (.val(man_v), .code(man_c));

    always_ff @(posedge clk) begin
      if (rst) begin
        mar_q[g] <= '0;
        pst_q[g] <= '0;
        man_q[g] <= '0;
        hi_q[g]  <= 1'b0;
        lo_q[g]  <= 1'b0;
      end else if (start) begin
        mar_q[g] <= mar_c;
        pst_q[g] <= pst_c;
        man_q[g] <= man_c;
        hi_q[g]  <= c_hi;
        lo_q[g]  <= c_lo;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= start;
  end

  assign res_valid     = vld_q;
  assign margin_p_code = mar_q[POL_P];
  assign margin_n_code = mar_q[POL_N];
  assign post_p_code   = pst_q[POL_P];
  assign post_n_code   = pst_q[POL_N];
  assign main_p_code   = man_q[POL_P];
  assign main_n_code   = man_q[POL_N];
  assign warn_high     = hi_q;
  assign warn_low      = lo_q;
endmodule

// File: rtl/zseg_checker.sv
module zseg_checker #(
  parameter int unsigned RAW_W   = 9,
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned Q_MAX   = 132,
  parameter int unsigned Q_DEF   = 100,
  parameter int unsigned CODE_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               cal_ok,
  input logic [RAW_W-1:0]   raw_p,
  input logic [RAW_W-1:0]   raw_n,
  input logic [RATIO_W-1:0] margin_ratio,
  input logic [RATIO_W-1:0] tap_ratio,
  input logic               res_valid,
  input logic [CODE_W-1:0]  margin_p_code,
  input logic [CODE_W-1:0]  margin_n_code,
  input logic [CODE_W-1:0]  post_p_code,
  input logic [CODE_W-1:0]  post_n_code,
  input logic [CODE_W-1:0]  main_p_code,
  input logic [CODE_W-1:0]  main_n_code,
  input logic [1:0]         warn_high,
  input logic [1:0]         warn_low
);
  localparam logic [CODE_W-1:0] MAIN_TOP = CODE_W'((Q_MAX + 1) / 2);
  localparam logic [CODE_W-1:0] MAR_TOP  = CODE_W'((Q_MAX / 2 + 1) / 2);
  localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'((Q_DEF + 1) / 2);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);
  a_r2_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid);
  a_r2_hold_codes: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(main_p_code) && $stable(main_n_code) &&
                $stable(margin_p_code) && $stable(margin_n_code) &&
                $stable(post_p_code) && $stable(post_n_code) &&
                $stable(warn_high) && $stable(warn_low)));
  a_r4_default_no_warn: assert property (@(posedge clk) disable iff (rst)
    (start && !cal_ok) |=> (warn_high == 2'b00 && warn_low == 2'b00));
  a_r4_default_main: assert property (@(posedge clk) disable iff (rst)
    (start && !cal_ok && margin_ratio == '0 && tap_ratio == '0)
      |=> (main_p_code == DEF_CODE && main_n_code == DEF_CODE));
  a_r5_warn_exclusive: assert property (@(posedge clk) disable iff (rst)
    (warn_high & warn_low) == 2'b00);
  a_r9_main_bound: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (main_p_code <= MAIN_TOP && main_n_code <= MAIN_TOP));
  a_r7_margin_bound: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (margin_p_code <= MAR_TOP && margin_n_code <= MAR_TOP));
endmodule

bind zcal_seg_split zseg_checker #(
  .RAW_W(RAW_W), .RATIO_W(RATIO_W), .Q_MAX(Q_MAX), .Q_DEF(Q_DEF), .CODE_W(CODE_W)
) i_zseg_checker (.*);

// File: tb/test_zcal_seg_split.sv
module test_zcal_seg_split;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cal_ok = 1'b0;
  logic [8:0] raw_p = '0, raw_n = '0;
  logic [7:0] margin_ratio = '0, tap_ratio = '0;
  logic       res_valid;
  logic [7:0] margin_p_code, margin_n_code, post_p_code, post_n_code;
  logic [7:0] main_p_code, main_n_code;
  logic [1:0] warn_high, warn_low;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  zcal_seg_split i_zcal_seg_split (
    .clk(clk), .rst(rst), .start(start), .cal_ok(cal_ok),
    .raw_p(raw_p), .raw_n(raw_n),
    .margin_ratio(margin_ratio), .tap_ratio(tap_ratio),
    .res_valid(res_valid),
    .margin_p_code(margin_p_code), .margin_n_code(margin_n_code),
    .post_p_code(post_p_code), .post_n_code(post_n_code),
    .main_p_code(main_p_code), .main_n_code(main_n_code),
    .warn_high(warn_high), .warn_low(warn_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected values from the requirements: {mar, pst, man, hi, lo}
  task automatic model(input bit ok, input int raw, input int rm, input int rk,
                       output int mar, output int pst, output int man,
                       output int hi, output int lo);
    int q, m, t, rest, ms, ks;
    hi = 0; lo = 0;
    q = raw / 2;                       // R3
    if (!ok) q = 100;                  // R4
    else if (q > 132) begin q = 132; hi = 1; end   // R5
    else if (q < 64)  begin q = 64;  lo = 1; end   // R6
    ms = (rm > 128) ? 128 : rm;
    ks = (rk > 128) ? 128 : rk;
    m = (ms * (q / 2)) / 128;          // R7
    rest = q - 2 * m;
    t = (ks * rest) / 128;             // R8
    mar = (m + 1) / 2;                 // R10
    pst = (t + 1) / 2;
    man = (rest - t + 1) / 2;          // R9
  endtask

  task automatic check_all(input bit ok, input int rp, input int rn,
                           input int rm, input int rk, input string ph);
    int mp, tp, np, hp, lp, mn, tn, nn, hn, ln;
    model(ok, rp, rm, rk, mp, tp, np, hp, lp);
    model(ok, rn, rm, rk, mn, tn, nn, hn, ln);
    chk({ph, " R7 R10 margin_p"}, margin_p_code, mp);
    chk({ph, " R7 R10 margin_n"}, margin_n_code, mn);
    chk({ph, " R8 R10 post_p"}, post_p_code, tp);
    chk({ph, " R8 R10 post_n"}, post_n_code, tn);
    chk({ph, " R3 R9 main_p"}, main_p_code, np);
    chk({ph, " R3 R9 main_n"}, main_n_code, nn);
    chk({ph, ok ? " R5 warn_high" : " R4 warn_high"}, warn_high, {hn[0], hp[0]});
    chk({ph, ok ? " R6 warn_low" : " R4 warn_low"}, warn_low, {ln[0], lp[0]});
  endtask

  task automatic run_vec(input bit ok, input int rp, input int rn,
                         input int rm, input int rk);
    @(negedge clk);
    cal_ok = ok; raw_p = 9'(rp); raw_n = 9'(rn);
    margin_ratio = 8'(rm); tap_ratio = 8'(rk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 valid pulse", res_valid, 1);
    check_all(ok, rp, rn, rm, rk, "result");
    // Scramble inputs without start: outputs must not move (R2).
    cal_ok = ~ok; raw_p = ~raw_p; raw_n = raw_n + 9'd37;
    margin_ratio = ~margin_ratio; tap_ratio = tap_ratio + 8'd90;
    @(negedge clk);
    chk("R2 valid low", res_valid, 0);
    check_all(ok, rp, rn, rm, rk, "R2 hold");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int rms[7];
    int rks[7];
    rms = '{0, 64, 0, 128, 255, 6, 96};
    rks = '{0, 0, 64, 128, 200, 15, 32};
    repeat (3) @(negedge clk);
    // R1: reset state, held while inputs move
    cal_ok = 1'b1; raw_p = 9'd300; margin_ratio = 8'd50;
    chk("R1 valid in reset", res_valid, 0);
    chk("R1 main_p in reset", main_p_code, 0);
    chk("R1 warn in reset", {warn_high, warn_low}, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 valid after reset", res_valid, 0);
    chk("R1 codes after reset",
        margin_p_code | margin_n_code | post_p_code | post_n_code |
        main_p_code | main_n_code, 0);
    chk("R1 warn after reset", {warn_high, warn_low}, 0);

    // Default path (R4) across ratios and raw values
    for (int i = 0; i < 7; i++) begin
      run_vec(1'b0, 511, 0, rms[i], rks[i]);
      run_vec(1'b0, 200, 150, rms[i], rks[i]);
    end

    // Clamp window edges (R5, R6)
    run_vec(1'b1, 264, 265, 0, 0);
    run_vec(1'b1, 266, 267, 0, 0);
    run_vec(1'b1, 128, 127, 0, 0);
    run_vec(1'b1, 126, 129, 128, 128);

    // Full sweep: P over every raw value, N mirrored
    for (int i = 0; i < 7; i++) begin
      for (int r = 0; r < 512; r++) begin
        run_vec(1'b1, r, 511 - r, rms[i], rks[i]);
      end
    end

    // Back-to-back starts: valid stays high each cycle (R2)
    @(negedge clk);
    cal_ok = 1'b1; raw_p = 9'd200; raw_n = 9'd220;
    margin_ratio = 8'd32; tap_ratio = 8'd10; start = 1'b1;
    @(negedge clk);
    chk("R2 first of pair", res_valid, 1);
    raw_p = 9'd180;
    @(negedge clk);
    start = 1'b0;
    chk("R2 second of pair", res_valid, 1);
    check_all(1'b1, 180, 220, 32, 10, "R2 back-to-back");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule